// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block collects 32 level-sensitive interrupt sources into one raw level vector and drives two independent outputs from it: a normal interrupt request and a fast interrupt request. Each output has its own enable mask. Software changes a mask through a pair of addresses, one that sets the written bits and one that clears them, so no read-modify-write is needed. Source 0 can also be raised and lowered by software, which lets software trigger an interrupt for test or for inter-task signalling.

A processor reads the masked status of each output, the raw levels and both masks through a 32-bit word-addressed register bus. Reads are combinational. Writes take effect on the clock edge. The block does no priority encoding and no vectoring. Several controllers can be chained by feeding the output of one into a source input of another.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Bit n of the raw level equals source input n while that input is held. Bit 0 is the OR of source input 0 and the software source bit. Reading word 1 or word 9 returns the raw level.
- R2: Reading word 0 returns the raw level ANDed with the normal-request mask. Reading word 8 returns the raw level ANDed with the fast-request mask.
- R3: Reading word 2 returns the normal-request mask. Reading word 10 returns the fast-request mask.
- R4: A write to word 2 ORs the write data into the normal-request mask. A write to word 10 does the same for the fast-request mask.
- R5: A write to word 3 clears the normal-request mask bits that are 1 in the write data. A write to word 11 does the same for the fast-request mask. Mask bits that are 0 in the write data are kept.
- R6: A write to word 4 with data bit 0 equal to 1 sets the software source bit. A write to word 5 with data bit 0 equal to 1 clears it. Writes to these words with bit 0 equal to 0 leave it unchanged. Reading word 4 returns raw bit 0 in bit 0 and zero in every other bit.
- R7: Reads of words 3, 5 and 11 return zero. So do reads of every word not named in R1 to R6.
- R8: Writes to words 0, 1, 8 and 9 change neither mask nor the software source bit.
- R9: Both outputs are registered. After each clock edge, irq_o equals the OR reduction of (raw level AND normal-request mask) as it stood before that edge. fiq_o is formed the same way with the fast-request mask.
- R10: Reset clears both masks and the software source bit, and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| src_i | input | 32 | Level-sensitive interrupt sources |
| we_i | input | 1 | Write strobe for the register bus |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
A corrupted mask bit shows up at the same time as a wrong read of word 2 or word 10. One cycle later it shows up on the matching output, as soon as that source is active. A stuck software source bit is visible in the same cycle through raw bit 0 in words 1, 4 and 9. The bench reads a random address on every cycle and compares both outputs on every cycle. A wrong state therefore shows up within a cycle of the first stimulus that exposes it.

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam logic [AW-1:0] W_ISTAT = AW'(0);
  localparam logic [AW-1:0] W_IRAW  = AW'(1);
  localparam logic [AW-1:0] W_IEN   = AW'(2);
  localparam logic [AW-1:0] W_IDIS  = AW'(3);
  localparam logic [AW-1:0] W_SWSET = AW'(4);
  localparam logic [AW-1:0] W_SWCLR = AW'(5);
  localparam logic [AW-1:0] W_FSTAT = AW'(8);
  localparam logic [AW-1:0] W_FRAW  = AW'(9);
  localparam logic [AW-1:0] W_FEN   = AW'(10);
  localparam logic [AW-1:0] W_FDIS  = AW'(11);

  logic [NSRC-1:0] irq_mask, fiq_mask, raw;
  logic            sw_src;
  logic [NSRC-1:0] wbits;

  assign wbits = wdata_i[NSRC-1:0];
  assign raw   = src_i | {{(NSRC-1){1'b0}}, sw_src};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask <= '0;
      fiq_mask <= '0;
      sw_src   <= 1'b0;
      irq_o    <= 1'b0;
      fiq_o    <= 1'b0;
    end else begin
      irq_o <= |(raw & irq_mask);
      fiq_o <= |(raw & fiq_mask);
      if (we_i) begin
        case (addr_i)
          W_IEN:   irq_mask <= irq_mask | wbits;
          W_IDIS:  irq_mask <= irq_mask & ~wbits;
          W_FEN:   fiq_mask <= fiq_mask | wbits;
          W_FDIS:  fiq_mask <= fiq_mask & ~wbits;
          W_SWSET: if (wdata_i[0]) sw_src <= 1'b1;
          W_SWCLR: if (wdata_i[0]) sw_src <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      W_ISTAT:        rdata_o[NSRC-1:0] = raw & irq_mask;
      W_IRAW, W_FRAW: rdata_o[NSRC-1:0] = raw;
      W_IEN:          rdata_o[NSRC-1:0] = irq_mask;
      W_SWSET:        rdata_o[0]        = raw[0];
      W_FSTAT:        rdata_o[NSRC-1:0] = raw & fiq_mask;
      W_FEN:          rdata_o[NSRC-1:0] = fiq_mask;
      default:        ;
    endcase
  end

  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == W_IEN) |=> ((irq_mask & $past(wbits)) == $past(wbits)));
  a_r5_fiq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == W_FDIS) |=> ((fiq_mask & $past(wbits)) == '0));
  a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == W_SWSET && wdata_i[0]) |=> raw[0]);
  a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (addr_i == W_ISTAT || addr_i == W_IRAW || addr_i == W_FSTAT || addr_i == W_FRAW))
    |=> ($stable(irq_mask) && $stable(fiq_mask) && $stable(sw_src)));
  a_r9_irq_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |=> !irq_o);
  a_r9_fiq_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_mask == '0) |=> !fiq_o);
  a_r9_quiet_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |=> (!irq_o && !fiq_o));
endmodule

// File: tb/dual_irq_ctrl_bench.sv
module dual_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_irq = '0, m_fiq = '0;
  logic        m_sw = 1'b0;

  always #2 clk = ~clk;

  dual_irq_ctrl u_dual_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] r;
    r = src | {31'b0, m_sw};
    case (a)
      4'd0:  return r & m_irq;
      4'd1:  return r;
      4'd2:  return m_irq;
      4'd4:  return {31'b0, r[0]};
      4'd8:  return r & m_fiq;
      4'd9:  return r;
      4'd10: return m_fiq;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd8:  return "R2";
      4'd1, 4'd9:  return "R1";
      4'd2, 4'd10: return "R3";
      4'd4:        return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] s, input logic w, input logic [3:0] a, input logic [31:0] d);
    logic ei, ef;
    logic [31:0] r;
    src = s; we = w; addr = a; wdata = d;
    #1;
    check(tag_of(a), rdata, exp_read(a));
    r  = src | {31'b0, m_sw};
    ei = |(r & m_irq);
    ef = |(r & m_fiq);
    @(posedge clk);
    if (w) begin
      case (a)
        4'd2:  m_irq = m_irq | d;
        4'd3:  m_irq = m_irq & ~d;
        4'd10: m_fiq = m_fiq | d;
        4'd11: m_fiq = m_fiq & ~d;
        4'd4:  if (d[0]) m_sw = 1'b1;
        4'd5:  if (d[0]) m_sw = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk);
    we = 1'b0;
    check("R9 irq", {31'b0, irq}, {31'b0, ei});
    check("R9 fiq", {31'b0, fiq}, {31'b0, ef});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    src = 32'hffff_ffff;
    @(negedge clk);
    check("R10 irq low in reset", {31'b0, irq}, 32'h0);
    check("R10 fiq low in reset", {31'b0, fiq}, 32'h0);
    rst_n = 1'b1;
    // R10: masks zero after reset
    step(32'hffff_ffff, 1'b0, 4'd2, 0);
    step(32'hffff_ffff, 1'b0, 4'd10, 0);
    // R4 / R3 directed
    step(32'h0000_0100, 1'b1, 4'd2, 32'h0000_0300);
    step(32'h0000_0100, 1'b1, 4'd2, 32'h8000_0000);
    step(32'h0000_0100, 1'b0, 4'd2, 0);
    step(32'h0000_0000, 1'b1, 4'd10, 32'h0000_0001);
    // R6 soft source drives fiq through bit 0
    step(32'h0, 1'b1, 4'd4, 32'h0000_0001);
    step(32'h0, 1'b0, 4'd4, 0);
    step(32'h0, 1'b0, 4'd1, 0);
    step(32'h0, 1'b1, 4'd4, 32'h0000_0000);
    step(32'h0, 1'b1, 4'd5, 32'h0000_0001);
    step(32'h1, 1'b0, 4'd4, 0);
    step(32'h0, 1'b1, 4'd5, 32'h0000_0000);
    // R8 writes to status words ignored
    step(32'h0, 1'b1, 4'd0, 32'hffff_ffff);
    step(32'h0, 1'b1, 4'd9, 32'hffff_ffff);
    step(32'h0, 1'b0, 4'd10, 0);
    step(32'h0, 1'b0, 4'd2, 0);
    // R5 partial clear keeps other bits
    step(32'h0, 1'b1, 4'd3, 32'h0000_0100);
    step(32'h0, 1'b0, 4'd2, 0);
    step(32'h0, 1'b1, 4'd11, 32'hffff_ffff);
    // R7 write-only and unmapped reads
    step(32'h1234_5678, 1'b0, 4'd3, 0);
    step(32'h1234_5678, 1'b0, 4'd5, 0);
    step(32'h1234_5678, 1'b0, 4'd11, 0);
    step(32'h1234_5678, 1'b0, 4'd15, 0);
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] s, d;
      logic [3:0]  a;
      s = ($urandom % 3 == 0) ? 32'h0 : ($urandom & $urandom & $urandom);
      a = 4'($urandom);
      d = $urandom & $urandom;
      step(s, ($urandom % 2) == 1, a, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule